// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is the input side of a slave-mode serial audio port. A bit clock and a frame (word-select) clock arrive from an external master, together with three data lines that share that timing. The block samples the data into a 24-bit shift register per line. A frame controller decides which bit clocks fall inside the active word and where each half frame ends. At the end of every right-channel half it hands out one left word and one right word per line, left-aligned in a 24-bit slot, together with a one-cycle valid strobe.

All inputs are oversampled by a faster system clock through a short synchronizer. The framing is chosen by a 3-bit format code. The block copies that code only while its synchronous active-low reset is held, so the framing cannot change while audio runs. Codes that name no framing raise an error flag and block the strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is low, and on the first clock after it is released, `valid_o` is 0 and every word on `left_o` and `right_o` is 0.
- R2: The format code is copied from `fmt_i` only while reset is low. A change on `fmt_i` after release has no effect on decoding or on `fmt_err_o`.
- R3: Code 0 is 16-bit LSB-justified. The word is taken from the last 16 bit clocks of each half frame, MSB first, and is output in bits [23:8] with bits [7:0] zero.
- R4: Code 1 is 20-bit LSB-justified, taken from the last 20 bit clocks of each half frame and output in bits [23:4] with bits [3:0] zero.
- R5: Code 4 is 24-bit LSB-justified, taken from the last 24 bit clocks of each half frame.
- R6: Code 2 is MSB-justified. The MSB is on the first bit clock after the frame-clock edge and up to 24 bits are taken. When the half frame is shorter, the bits received are left-aligned with zero fill.
- R7: Code 3 is I2S. The MSB comes one bit clock after the frame-clock edge and up to 24 bits are taken. In a 16-clock half frame the LSB arrives on the first bit clock of the next half and still belongs to the earlier word.
- R8: The left word is the half frame with the frame clock high in codes 0, 1, 2 and 4, and with the frame clock low in code 3.
- R9: Bits outside the active word window have no effect on the output words.
- R10: The bit position restarts on every frame-clock edge, so 32, 48 and 64 bit clocks per frame all decode correctly.
- R11: `valid_o` is a single-cycle pulse, once per complete left-then-right frame, issued when the right word is stored. The partial half frame seen before the first frame-clock edge after reset yields no word.
- R12: Codes 5, 6 and 7 set `fmt_err_o` to 1 and no `valid_o` pulse appears. Legal codes leave `fmt_err_o` at 0.
- R13: The three data lines are decoded with the same timing into independent words. Line k occupies bits [24k+23:24k] of each output bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample all serial inputs |
| rst_n | input | 1 | Synchronous active-low reset; the format code is copied while it is low |
| sck_i | input | 1 | External serial bit clock; data is taken on its rising edge |
| ws_i | input | 1 | External frame clock selecting the channel half |
| sd_i | input | 3 | Serial data lines, one per lane |
| fmt_i | input | 3 | Framing code (0..4 legal, 5..7 reserved) |
| left_o | output | 72 | Left words, 24 bits per lane, left-aligned |
| right_o | output | 72 | Right words, 24 bits per lane, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a new frame of words is available |
| fmt_err_o | output | 1 | Reserved framing code was latched |

## Verification
The bench pads every bit outside the word window with ones. A design that counted LSB-justified words from the frame edge instead of from the end of the half, or that kept shifting past 24 bits in MSB or I2S framing, would corrupt the upper or lower bits of the word. The 16-clock I2S half frame is the hardest case: a design that closed the word at the frame edge would lose the LSB and shift the whole word by one place. The bench also runs 32, 48 and 64 clocks per frame, flips the format pin after reset, and feeds reserved codes. A design with a fixed half length, a live format pin or a missing reserved-code gate would then give wrong words, extra strobes or a wrong error flag.

// File: rtl/audrx_pkg.sv
// Shared types for the serial audio receiver.
// Assumes a fixed 24-bit output slot; word lengths are counted in bits.
package audrx_pkg;

    localparam int unsigned SLOT_W = 24;
    localparam int unsigned CNT_W  = $clog2(SLOT_W + 1);

    typedef enum logic [1:0] {
        JUST_LSB = 2'd0,
        JUST_MSB = 2'd1,
        JUST_I2S = 2'd2
    } just_e;

    typedef struct packed {
        just_e              just;
        logic [CNT_W-1:0]   wlen;
        logic               bad;
    } fmt_cfg_t;

    // Map the pin code to a justification, a word length and a reserved flag.
    function automatic fmt_cfg_t decode_fmt(input logic [2:0] code);
        fmt_cfg_t c;
        c.bad  = 1'b0;
        c.wlen = CNT_W'(SLOT_W);
        c.just = JUST_LSB;
        case (code)
            3'd0: c.wlen = CNT_W'(16);
            3'd1: c.wlen = CNT_W'(20);
            3'd2: c.just = JUST_MSB;
            3'd3: c.just = JUST_I2S;
            3'd4: c.wlen = CNT_W'(SLOT_W);
            default: c.bad = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/audrx_sync.sv
// Input synchronizer and bit-clock edge detector.
// Assumes the system clock runs at least 4x faster than the bit clock and that
// data and frame clock are stable around the bit-clock rising edge.
module audrx_sync #(
    parameter int unsigned LANES  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_i,
    input  logic             ws_i,
    input  logic [LANES-1:0] sd_i,
    output logic             bit_stb,
    output logic             ws_s,
    output logic [LANES-1:0] sd_s
);

    logic [STAGES-1:0]            sck_pipe;
    logic [STAGES-1:0]            ws_pipe;
    logic [STAGES-1:0][LANES-1:0] sd_pipe;
    logic                         sck_last;

    // Move all serial inputs through the same number of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            ws_pipe  <= '0;
            sd_pipe  <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_pipe <= {sck_pipe[STAGES-2:0], sck_i};
            ws_pipe  <= {ws_pipe[STAGES-2:0], ws_i};
            sd_pipe  <= {sd_pipe[STAGES-2:0], sd_i};
            sck_last <= sck_pipe[STAGES-1];
        end
    end

    assign bit_stb = sck_pipe[STAGES-1] & ~sck_last;
    assign ws_s    = ws_pipe[STAGES-1];
    assign sd_s    = sd_pipe[STAGES-1];

endmodule

// File: rtl/audrx_frame_ctl.sv
// Frame controller shared by all lanes.
// Tracks the frame-clock edges and the bit position inside the half frame, and
// decides per bit whether lanes shift, add an I2S tail bit or close a word.
// Assumes the format config is constant outside reset.
module audrx_frame_ctl
    import audrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  fmt_cfg_t         cfg,
    input  logic             bit_stb,
    input  logic             ws_s,
    output logic             shift_en,
    output logic             tail_en,
    output logic             fin_en,
    output logic             fin_left,
    output logic [CNT_W-1:0] nbits,
    output logic             valid_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOT_W);

    logic             seen_q;
    logic             ws_prev_q;
    logic             started_q;
    logic             have_left_q;
    logic [CNT_W-1:0] cnt_q;
    logic             valid_q;
    logic             edge_w;
    logic             is_i2s;
    logic             is_lsb;
    logic             room;

    // Per-bit decisions derived from the edge and the bit count.
    always_comb begin
        is_i2s   = (cfg.just == JUST_I2S);
        is_lsb   = (cfg.just == JUST_LSB);
        edge_w   = bit_stb && seen_q && (ws_s != ws_prev_q);
        room     = (cnt_q < FULL);
        shift_en = bit_stb && (is_lsb || (edge_w ? !is_i2s : room));
        tail_en  = edge_w && is_i2s && room;
        fin_en   = edge_w && started_q;
        fin_left = ws_prev_q ^ is_i2s;
        nbits    = is_lsb ? cfg.wlen : CNT_W'(cnt_q + CNT_W'(tail_en));
    end

    // Bit counter, frame-clock history and left/right pairing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            ws_prev_q   <= 1'b0;
            started_q   <= 1'b0;
            have_left_q <= 1'b0;
            cnt_q       <= '0;
            valid_q     <= 1'b0;
        end else begin
            valid_q <= fin_en && !fin_left && have_left_q && !cfg.bad;
            if (bit_stb) begin
                seen_q    <= 1'b1;
                ws_prev_q <= ws_s;
                if (edge_w) begin
                    started_q <= 1'b1;
                    cnt_q     <= is_i2s ? '0 : CNT_W'(1);
                    if (fin_en) begin
                        have_left_q <= fin_left;
                    end
                end else if (room) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign valid_o = valid_q;

endmodule

// File: rtl/audrx_lane.sv
// One data lane: shift register, word alignment and left/right holding regs.
// Assumes the frame controller's strobes; the left-aligned word keeps the
// nbits most recent bits and fills below with zero.
module audrx_lane
    import audrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sd_i,
    input  logic              shift_en,
    input  logic              tail_en,
    input  logic              fin_en,
    input  logic              fin_left,
    input  logic [CNT_W-1:0]  nbits,
    output logic [SLOT_W-1:0] left_o,
    output logic [SLOT_W-1:0] right_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOT_W);

    logic [SLOT_W-1:0] shreg_q;
    logic [SLOT_W-1:0] src;
    logic [SLOT_W-1:0] aligned;
    logic [CNT_W-1:0]  pad_w;

    // Build the closing word, including an I2S tail bit when requested.
    always_comb begin
        src     = tail_en ? {shreg_q[SLOT_W-2:0], sd_i} : shreg_q;
        pad_w   = FULL - nbits;
        aligned = src << pad_w;
    end

    // Shift serial bits in and store closed words by channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            left_o  <= '0;
            right_o <= '0;
        end else begin
            if (shift_en) begin
                shreg_q <= {shreg_q[SLOT_W-2:0], sd_i};
            end
            if (fin_en) begin
                if (fin_left) begin
                    left_o <= aligned;
                end else begin
                    right_o <= aligned;
                end
            end
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
// Top of the multi-format serial audio receiver.
// Copies the format code while reset is low, synchronizes the serial inputs,
// and runs one shared frame controller over LANES data lanes.
module serial_audio_rx
    import audrx_pkg::*;
#(
    parameter int unsigned LANES       = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sck_i,
    input  logic                    ws_i,
    input  logic [LANES-1:0]        sd_i,
    input  logic [2:0]              fmt_i,
    output logic [LANES*SLOT_W-1:0] left_o,
    output logic [LANES*SLOT_W-1:0] right_o,
    output logic                    valid_o,
    output logic                    fmt_err_o
);

    fmt_cfg_t         cfg_q;
    logic             bit_stb;
    logic             ws_s;
    logic [LANES-1:0] sd_s;
    logic             shift_en;
    logic             tail_en;
    logic             fin_en;
    logic             fin_left;
    logic [CNT_W-1:0] nbits;

    // Follow the format pins during reset, hold them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= decode_fmt(fmt_i);
        end
    end

    assign fmt_err_o = cfg_q.bad;

    audrx_sync #(
        .LANES  (LANES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_i   (sck_i),
        .ws_i    (ws_i),
        .sd_i    (sd_i),
        .bit_stb (bit_stb),
        .ws_s    (ws_s),
        .sd_s    (sd_s)
    );

    audrx_frame_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg_q),
        .bit_stb  (bit_stb),
        .ws_s     (ws_s),
        .shift_en (shift_en),
        .tail_en  (tail_en),
        .fin_en   (fin_en),
        .fin_left (fin_left),
        .nbits    (nbits),
        .valid_o  (valid_o)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        audrx_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .sd_i     (sd_s[k]),
            .shift_en (shift_en),
            .tail_en  (tail_en),
            .fin_en   (fin_en),
            .fin_left (fin_left),
            .nbits    (nbits),
            .left_o   (left_o[k*SLOT_W +: SLOT_W]),
            .right_o  (right_o[k*SLOT_W +: SLOT_W])
        );
    end

endmodule

// File: rtl/audrx_checker.sv
// Property checker for serial_audio_rx, attached with bind below.
// Watches the strobe, the error flag, the latched word length and the words.
module audrx_checker #(
    parameter int unsigned LANES  = 3,
    parameter int unsigned SLOT_W = 24,
    parameter int unsigned CNT_W  = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bit_stb,
    input logic                    valid_o,
    input logic                    fmt_err_o,
    input logic [CNT_W-1:0]        cfg_wlen,
    input logic [LANES*SLOT_W-1:0] left_o,
    input logic [LANES*SLOT_W-1:0] right_o
);

    logic pad_ok;

    // Every word must be zero below its latched word length.
    always_comb begin
        pad_ok = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if (((left_o[k*SLOT_W +: SLOT_W] << cfg_wlen) != '0) ||
                ((right_o[k*SLOT_W +: SLOT_W] << cfg_wlen) != '0)) begin
                pad_ok = 1'b0;
            end
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !valid_o);

    p_fmt_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(fmt_err_o) && $stable(cfg_wlen)));

    // R3 and R4: zero fill below short LSB-justified words
    p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> pad_ok);

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_after_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(bit_stb));

    p_err_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err_o |-> !valid_o);

endmodule

bind serial_audio_rx audrx_checker #(
    .LANES  (LANES),
    .SLOT_W (audrx_pkg::SLOT_W),
    .CNT_W  (audrx_pkg::CNT_W)
) u_audrx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .valid_o   (valid_o),
    .fmt_err_o (fmt_err_o),
    .cfg_wlen  (cfg_q.wlen),
    .left_o    (left_o),
    .right_o   (right_o)
);

// File: tb/test_serial_audio_rx.sv
// Scoreboard bench: the driver serializes frames and queues expected words,
// the monitor compares them whenever the strobe fires.
module test_serial_audio_rx;

    localparam int LANES = 3;
    localparam int W     = 24;
    localparam int BW    = LANES * W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sck = 1'b0;
    logic             ws = 1'b0;
    logic [LANES-1:0] sd = '1;
    logic [2:0]       fmt = 3'd0;
    logic [BW-1:0]    left_o;
    logic [BW-1:0]    right_o;
    logic             valid_o;
    logic             fmt_err_o;

    int               n_cmp = 0;
    int               n_bad = 0;
    logic [2*BW-1:0]  exp_q[$];
    string            tag_q[$];
    logic [LANES-1:0] pend;
    int unsigned      seed = 32'h1234_5678;

    always #5 clk = ~clk;

    serial_audio_rx #(.LANES(LANES)) i_serial_audio_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_i     (sck),
        .ws_i      (ws),
        .sd_i      (sd),
        .fmt_i     (fmt),
        .left_o    (left_o),
        .right_o   (right_o),
        .valid_o   (valid_o),
        .fmt_err_o (fmt_err_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rnd(input int wl);
        seed = seed * 32'd1103515245 + 32'd12345;
        return W'(((seed >> 4) ^ (seed << 9)) & ((32'd1 << wl) - 1));
    endfunction

    // Monitor: pop and compare one queued frame per strobe.
    always @(negedge clk) begin
        if (rst_n && valid_o === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R11/R12 unexpected strobe actual=1 expected=0");
            end else begin
                logic [2*BW-1:0] item;
                string tg;
                item = exp_q.pop_front();
                tg   = tag_q.pop_front();
                for (int k = 0; k < LANES; k++) begin
                    chk({tg, " R13"}, $sformatf("lane%0d left", k),
                        BW'(left_o[k*W +: W]), BW'(item[BW + k*W +: W]));
                    chk({tg, " R13"}, $sformatf("lane%0d right", k),
                        BW'(right_o[k*W +: W]), BW'(item[k*W +: W]));
                end
            end
        end
    end

    task automatic bit_out(input logic lr, input logic [LANES-1:0] d);
        @(negedge clk);
        sck = 1'b0; ws = lr; sd = d;
        repeat (3) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // One reset segment: latch code, optionally move the pin, stream frames.
    task automatic run_seg(input logic [2:0] code, input logic [2:0] pin_after,
                           input int bpf, input int wl, input int nfr,
                           input bit expect_out, input string tag);
        bit i2s, lsb;
        logic lvl;
        int h;
        logic [W-1:0] lw [LANES];
        logic [W-1:0] rw [LANES];
        logic [2*BW-1:0] item;
        logic [LANES-1:0] d;
        @(negedge clk);
        rst_n = 1'b0; fmt = code; sck = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "words in reset", left_o | right_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "strobe after release", BW'(valid_o), '0);
        chk("R12", "error flag", BW'(fmt_err_o), BW'(code > 3'd4));
        fmt = pin_after;
        i2s = (code == 3'd3);
        lsb = !(code == 3'd2 || code == 3'd3);
        lvl = i2s ? 1'b0 : 1'b1;
        h   = bpf / 2;
        pend = '1;
        repeat (4) bit_out(!lvl, '1);
        for (int f = 0; f < nfr; f++) begin
            for (int k = 0; k < LANES; k++) begin
                lw[k] = rnd(wl);
                rw[k] = rnd(wl);
                item[BW + k*W +: W] = W'(lw[k] << (W - wl));
                item[k*W +: W]      = W'(rw[k] << (W - wl));
            end
            if (expect_out) begin
                exp_q.push_back(item);
                tag_q.push_back(tag);
            end
            for (int hh = 0; hh < 2; hh++) begin
                for (int idx = 0; idx < h; idx++) begin
                    for (int k = 0; k < LANES; k++) begin
                        logic [W-1:0] w;
                        logic sb;
                        w = (hh == 0) ? lw[k] : rw[k];
                        if (lsb) sb = (idx >= h - wl) ? w[wl-1-(idx-(h-wl))] : 1'b1;
                        else     sb = (idx < wl) ? w[wl-1-idx] : 1'b1;
                        if (i2s) begin
                            d[k] = pend[k];
                            pend[k] = sb;
                        end else begin
                            d[k] = sb;
                        end
                    end
                    bit_out((hh == 0) ? lvl : !lvl, d);
                end
            end
        end
        bit_out(lvl, i2s ? pend : '1);
        bit_out(lvl, '1);
        repeat (20) @(negedge clk);
        chk("R2", "error flag after pin change", BW'(fmt_err_o), BW'(code > 3'd4));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1", "strobe in reset", BW'(valid_o), '0);
        chk("R1", "left in reset", left_o, '0);
        chk("R1", "right in reset", right_o, '0);
        run_seg(3'd0, 3'd0, 64, 16, 3, 1'b1, "R3 R8 R9");
        run_seg(3'd0, 3'd0, 32, 16, 2, 1'b1, "R3 R10");
        run_seg(3'd1, 3'd1, 64, 20, 2, 1'b1, "R4 R9");
        run_seg(3'd4, 3'd4, 48, 24, 2, 1'b1, "R5 R10");
        run_seg(3'd4, 3'd4, 64, 24, 2, 1'b1, "R5 R9");
        run_seg(3'd2, 3'd2, 64, 24, 2, 1'b1, "R6 R9");
        run_seg(3'd2, 3'd2, 32, 16, 2, 1'b1, "R6 R10");
        run_seg(3'd3, 3'd3, 64, 24, 2, 1'b1, "R7 R8");
        run_seg(3'd3, 3'd3, 32, 16, 2, 1'b1, "R7 R10");
        run_seg(3'd3, 3'd3, 48, 24, 2, 1'b1, "R7");
        run_seg(3'd0, 3'd3, 64, 16, 2, 1'b1, "R2");
        run_seg(3'd5, 3'd5, 64, 24, 2, 1'b0, "R12");
        run_seg(3'd7, 3'd0, 64, 24, 1, 1'b0, "R12");
        chk("R11", "frames left without strobe", BW'(exp_q.size()), '0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog run did not end actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule